// File: doc/BRIEF.md
# Three-Source Raster Logic Datapath

This block takes three 16-bit source words per clock and produces one destination word. The destination is any bitwise Boolean function of the three sources, chosen by an 8-bit truth-table code. Sources A and B each pass through their own barrel shifter. Bits pushed out of one word are carried into the next word of the same row, so a bitmap can be placed at any pixel offset. Source A can also be trimmed at the edges of a row by two edge masks.

A sequencer outside the block fetches the words, flags the first and last word of each row, and writes the results back. For each word it presents the shift amounts, masks, direction, channel enables and function code together with the data. Any source whose channel is switched off is replaced by a fixed per-channel holding value. The result appears one clock later together with a valid strobe.

Top module: `rop3_datapath`

## Requirements
- R1: For each bit position i, out_word[i] equals func[{a_i,b_i,c_i}], where a_i, b_i and c_i are bit i of the processed A, B and C words, with A as the most significant bit of the 3-bit index.
- R2: The following codes give these results: 0xCA gives B where A is 1 and C where A is 0; 0xF0 copies A; 0xCC copies B; 0xAA copies C; 0x00 gives all zeros; 0xFF gives all ones.
- R3: With descend low, the processed A word is bits [15:0] of {prevA, curA} shifted right by shift_a (0..15). The processed B word is formed the same way from prevB, curB and shift_b. The two shift amounts are independent.
- R4: prevA and prevB are the gated words of the previous valid word in the same row. Bits shifted out of one word therefore enter the next word of the row.
- R5: On a word with first_word high, prevA and prevB are zero. The bits vacated by the shift are then 0.
- R6: Source A is ANDed with mask_first on a first word and with mask_last on a last word, and is left unmasked on a middle word. This gating is applied before the shift, and the gated word is the value carried to the next word. B and C are never masked.
- R7: A word that has both first_word and last_word high is ANDed with both masks.
- R8: When use_a, use_b or use_c is low, that source takes hold_a, hold_b or hold_c in place of its input word. The holding value then goes through the same masking and shifting.
- R9: With descend high, the processed word is bits [31:16] of {cur, prev} shifted left by the shift amount. Here prev is the previously presented word of the row, which is the following word in memory.
- R10: out_word and out_valid are registered. A word presented with in_valid high appears on the next clock with out_valid high. After a clock without in_valid, out_valid is low and out_word keeps its value.
- R11: After a synchronous reset, out_valid is 0, out_word is 0 and both carry registers are zero.
- R12: A word presented with in_valid low does not change the carry registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A source word set is present |
| first_word | input | 1 | Word is the first of its row |
| last_word | input | 1 | Word is the last of its row |
| descend | input | 1 | Left shift, carry from the following word |
| use_a | input | 1 | Channel A enable |
| use_b | input | 1 | Channel B enable |
| use_c | input | 1 | Channel C enable |
| src_a | input | 16 | Source A word |
| src_b | input | 16 | Source B word |
| src_c | input | 16 | Source C word |
| hold_a | input | 16 | Replacement for A when disabled |
| hold_b | input | 16 | Replacement for B when disabled |
| hold_c | input | 16 | Replacement for C when disabled |
| shift_a | input | 4 | Shift amount for A |
| shift_b | input | 4 | Shift amount for B |
| mask_first | input | 16 | Row-start mask for A |
| mask_last | input | 16 | Row-end mask for A |
| func | input | 8 | Truth-table function code |
| out_valid | output | 1 | out_word holds a new result |
| out_word | output | 16 | Destination word |

## Verification
A stale or wrong carry register shows up in the second or later word of a row as wrong high bits when ascending, or wrong low bits when descending. It appears one clock after that word is presented, and only when the shift is nonzero. A carry that survives a row boundary corrupts the vacated bits of the next row's first word. An idle cycle that updates the carry corrupts the word that follows it. Mask or selection faults appear at once in the same cycle's result, so they are visible on the next clock edge. The bench keeps an independent model of both carries, so any divergence is caught on the first word where it affects an output bit.

// File: rtl/rop3_pkg.sv
package rop3_pkg;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned SHIFT_W = $clog2(WORD_W);
    localparam int unsigned FUNC_W  = 8;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [SHIFT_W-1:0] shamt_t;
    typedef logic [FUNC_W-1:0]  func_t;

    // Row position of the current word
    typedef struct packed {
        logic head;
        logic tail;
        logic rev;
    } rowpos_t;

    // Processed triple feeding the logic stage
    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
    } triple_t;

    function automatic word_t pick_src(input logic en, input word_t live, input word_t held);
        return en ? live : held;
    endfunction

    function automatic word_t edge_gate(input rowpos_t pos, input word_t w,
                                        input word_t m_head, input word_t m_tail);
        word_t g;
        g = w;
        if (pos.head) g = g & m_head;
        if (pos.tail) g = g & m_tail;
        return g;
    endfunction
endpackage

// File: rtl/rop3_shift_lane.sv
module rop3_shift_lane
    import rop3_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  rowpos_t pos,
    input  logic    use_ch,
    input  word_t   src,
    input  word_t   hold,
    input  shamt_t  shift,
    input  word_t   mask_head,
    input  word_t   mask_tail,
    output word_t   word_out
);
    localparam int unsigned WIDE_W = 2 * WORD_W;

    word_t carry_q;
    word_t gated;
    word_t prev_eff;
    logic [WIDE_W-1:0] wide_r;
    logic [WIDE_W-1:0] wide_l;

    always_comb begin
        gated    = edge_gate(pos, pick_src(use_ch, src, hold), mask_head, mask_tail);
        prev_eff = pos.head ? '0 : carry_q;
        wide_r   = {prev_eff, gated} >> shift;
        wide_l   = {gated, prev_eff} << shift;
        word_out = pos.rev ? wide_l[WIDE_W-1:WORD_W] : wide_r[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            carry_q <= '0;
        else if (in_valid)
            carry_q <= gated;
    end

    // R5
    vacated_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pos.head && pos.rev) |-> ((word_out & ~(word_t'('1) << shift)) == '0));

    // R5
    vacated_high_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pos.head && !pos.rev) |-> ((word_out & ~(word_t'('1) >> shift)) == '0));

    // R6
    head_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pos.head && shift == '0) |-> ((word_out & ~mask_head) == '0));
endmodule

// File: rtl/rop3_minterm.sv
module rop3_minterm
    import rop3_pkg::*;
(
    input  triple_t trio,
    input  func_t   code,
    output word_t   result
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        logic [2:0] sel;
        assign sel       = {trio.a[i], trio.b[i], trio.c[i]};
        assign result[i] = code[sel];
    end
endmodule

// File: rtl/rop3_datapath.sv
module rop3_datapath
    import rop3_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        first_word,
    input  logic        last_word,
    input  logic        descend,
    input  logic        use_a,
    input  logic        use_b,
    input  logic        use_c,
    input  logic [15:0] src_a,
    input  logic [15:0] src_b,
    input  logic [15:0] src_c,
    input  logic [15:0] hold_a,
    input  logic [15:0] hold_b,
    input  logic [15:0] hold_c,
    input  logic [3:0]  shift_a,
    input  logic [3:0]  shift_b,
    input  logic [15:0] mask_first,
    input  logic [15:0] mask_last,
    input  logic [7:0]  func,
    output logic        out_valid,
    output logic [15:0] out_word
);
    rowpos_t pos;
    rowpos_t pos_plain;
    triple_t trio;
    word_t   comb_word;

    assign pos       = '{head: first_word, tail: last_word, rev: descend};
    assign pos_plain = '{head: first_word, tail: 1'b0, rev: descend};

    rop3_shift_lane u_lane_a (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pos(pos),
        .use_ch(use_a), .src(src_a), .hold(hold_a), .shift(shift_a),
        .mask_head(mask_first), .mask_tail(mask_last), .word_out(trio.a)
    );

    rop3_shift_lane u_lane_b (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pos(pos_plain),
        .use_ch(use_b), .src(src_b), .hold(hold_b), .shift(shift_b),
        .mask_head('1), .mask_tail('1), .word_out(trio.b)
    );

    assign trio.c = pick_src(use_c, src_c, hold_c);

    rop3_minterm u_logic (
        .trio(trio), .code(func), .result(comb_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_word <= comb_word;
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_word)));

    // R2
    clear_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == 8'h00) |=> (out_word == 16'h0000));

    // R2
    set_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == 8'hFF) |=> (out_word == 16'hFFFF));

    // R2
    copy_c_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == 8'hAA && use_c) |=> (out_word == $past(src_c)));
endmodule

// File: tb/rop3_datapath_test.sv
module rop3_datapath_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, first_word = 0, last_word = 0, descend = 0;
    logic use_a = 1, use_b = 1, use_c = 1;
    logic [15:0] src_a = 0, src_b = 0, src_c = 0;
    logic [15:0] hold_a = 0, hold_b = 0, hold_c = 0;
    logic [3:0]  shift_a = 0, shift_b = 0;
    logic [15:0] mask_first = 16'hFFFF, mask_last = 16'hFFFF;
    logic [7:0]  func = 0;
    logic        out_valid;
    logic [15:0] out_word;

    int checks = 0;
    int fails = 0;
    logic [15:0] m_pa = 0, m_pb = 0;
    logic [15:0] exp_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    rop3_datapath uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .first_word(first_word),
        .last_word(last_word), .descend(descend), .use_a(use_a), .use_b(use_b),
        .use_c(use_c), .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .hold_a(hold_a), .hold_b(hold_b), .hold_c(hold_c), .shift_a(shift_a),
        .shift_b(shift_b), .mask_first(mask_first), .mask_last(mask_last),
        .func(func), .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [15:0] m_shift(logic [15:0] cur, logic [15:0] prev,
                                            logic [3:0] s, logic d);
        logic [31:0] w;
        if (d) begin
            w = {cur, prev} << s;
            return w[31:16];
        end
        w = {prev, cur} >> s;
        return w[15:0];
    endfunction

    function automatic logic [15:0] m_logic(logic [15:0] a, logic [15:0] b,
                                            logic [15:0] c, logic [7:0] f);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = f[{a[i], b[i], c[i]}];
        return r;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one word at the falling edge, model it, check after next rising edge
    task automatic push(string tag, logic f, logic l, logic [15:0] a, logic [15:0] b,
                        logic [15:0] c);
        logic [15:0] ga, gb, ea, eb, ec, pa, pb;
        in_valid = 1; first_word = f; last_word = l;
        src_a = a; src_b = b; src_c = c;
        ga = use_a ? a : hold_a;
        if (f) ga = ga & mask_first;
        if (l) ga = ga & mask_last;
        gb = use_b ? b : hold_b;
        ec = use_c ? c : hold_c;
        pa = f ? 16'h0 : m_pa;
        pb = f ? 16'h0 : m_pb;
        ea = m_shift(ga, pa, shift_a, descend);
        eb = m_shift(gb, pb, shift_b, descend);
        exp_w = m_logic(ea, eb, ec, func);
        m_pa = ga; m_pb = gb;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        chk({tag, " valid"}, {15'd0, out_valid}, 16'd1);
        chk(tag, out_word, exp_w);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11 reset state
        chk("R11 reset valid", {15'd0, out_valid}, 16'd0);
        chk("R11 reset word", out_word, 16'h0000);

        // R2 composite and copies
        func = 8'hCA;
        push("R2 composite", 1, 1, 16'hFF00, 16'hF0F0, 16'h3C3C);
        chk("R2 composite literal", out_word, 16'hF03C);
        func = 8'hF0; push("R2 copy A", 1, 1, 16'h1357, 16'h0, 16'h0);
        chk("R2 copy A literal", out_word, 16'h1357);
        func = 8'hCC; push("R2 copy B", 1, 1, 16'h0, 16'h2468, 16'h0);
        chk("R2 copy B literal", out_word, 16'h2468);
        func = 8'hAA; push("R2 copy C", 1, 1, 16'h0, 16'h0, 16'h9ABC);
        func = 8'h00; push("R2 clear", 1, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        func = 8'hFF; push("R2 set", 1, 1, 16'h0, 16'h0, 16'h0);
        func = 8'h96; push("R1 parity code", 1, 1, 16'h0F0F, 16'h3333, 16'h5555);

        // R7 one-word row takes both masks
        func = 8'hF0; mask_first = 16'hFF00; mask_last = 16'h0FF0;
        push("R7 both masks", 1, 1, 16'hFFFF, 16'h0, 16'h0);
        chk("R7 literal", out_word, 16'h0F00);

        // R6 middle word unmasked, edges masked
        push("R6 first", 1, 0, 16'hFFFF, 16'h0, 16'h0);
        push("R6 middle", 0, 0, 16'hFFFF, 16'h0, 16'h0);
        chk("R6 middle literal", out_word, 16'hFFFF);
        push("R6 last", 0, 1, 16'hFFFF, 16'h0, 16'h0);
        mask_first = 16'hFFFF; mask_last = 16'hFFFF;

        // R8 disabled channel uses holding value
        use_a = 0; hold_a = 16'h5A5A;
        push("R8 hold A", 1, 1, 16'h1111, 16'h0, 16'h0);
        chk("R8 literal", out_word, 16'h5A5A);
        use_a = 1;

        // R3 R4 R12 carry across an idle cycle, ascending shift 4
        shift_a = 4;
        push("R5 first asc", 1, 0, 16'hABCD, 16'h0, 16'h0);
        chk("R5 literal", out_word, 16'h0ABC);
        src_a = 16'hFFFF; first_word = 1;
        @(posedge clk); @(negedge clk);
        chk("R10 idle valid", {15'd0, out_valid}, 16'd0);
        chk("R10 idle hold", out_word, 16'h0ABC);
        push("R4 R12 carry", 0, 1, 16'h1234, 16'h0, 16'h0);
        chk("R4 R12 literal", out_word, 16'hD123);

        // R9 descending
        descend = 1;
        push("R9 first desc", 1, 0, 16'hABCD, 16'h0, 16'h0);
        chk("R9 first literal", out_word, 16'hBCD0);
        push("R9 carry desc", 0, 1, 16'h1234, 16'h0, 16'h0);
        chk("R9 carry literal", out_word, 16'h234A);
        descend = 0;

        // R3 independent B shift
        shift_a = 0; shift_b = 8; func = 8'hCC;
        push("R3 B first", 1, 0, 16'h0, 16'h12AB, 16'h0);
        chk("R3 B literal", out_word, 16'h0012);

        // Random rows
        for (int r = 0; r < 400; r++) begin
            int len;
            len = 1 + ($urandom % 5);
            shift_a = 4'($urandom); shift_b = 4'($urandom);
            func = 8'($urandom); descend = 1'($urandom);
            use_a = ($urandom % 4) != 0; use_b = ($urandom % 4) != 0;
            use_c = ($urandom % 4) != 0;
            hold_a = 16'($urandom); hold_b = 16'($urandom); hold_c = 16'($urandom);
            mask_first = 16'($urandom); mask_last = 16'($urandom);
            for (int w = 0; w < len; w++) begin
                if (($urandom % 6) == 0) begin
                    src_a = 16'($urandom); first_word = 1'($urandom);
                    @(posedge clk); @(negedge clk);
                    chk("R12 R10 random idle", {15'd0, out_valid}, 16'd0);
                end
                push("R1/R3/R4/R6/R8/R9 random", w == 0, w == len - 1,
                     16'($urandom), 16'($urandom), 16'($urandom));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule